// File: doc/BRIEF.md
# Twisted-Pair Receive Path Loopback Selector

This block chooses what the back-end sees on its receive data path in a 10 Mb/s twisted-pair transceiver. On any cycle the receive path carries one of two sources. The first is the back-end's own transmit data, turned around internally. The second is the decoded line receive data with its carrier indication. The block also passes on a gated form of the collision indication and reports whether the internal turnaround is active.

Three source modes exist, in fixed priority. Forced loopback applies when the twisted-pair port is selected and the forced-loopback control bit is set. Next comes the strap-disabled mode, where an active-low strap turns off both the turnaround and collision reporting for full-duplex or external-cable testing. Last is the normal conditional mode. In normal mode the turnaround follows transmit enable, but a collision, link failure or jabber keeps it off. A new mode is taken only while transmit is idle or on the cycle transmit enable rises, so a frame never changes source because of a mode change. Every output is registered.

Top module: `lbk_path_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `rxd_out` is 0, `rxdv_out` is 0, `col_out` is 0 and `lb_active` is 0.
- R2: In normal mode (strap `ext_lb_n`=1, not forced), with `tx_en`=1 and `col_in`, `link_fail`, `jabber` all 0 and no collision earlier in the frame, the next cycle shows `rxd_out`=`tx_data`, `rxdv_out`=1 and `lb_active`=1.
- R3: When the turnaround is not active, the next cycle shows `rxd_out`=`rx_data`, `rxdv_out`=`rx_crs` and `lb_active`=0.
- R4: In normal mode a collision seen while `tx_en`=1 switches the receive path to line data from that cycle until `tx_en` falls, even once `col_in` drops. In normal and forced modes `col_out` repeats `col_in` one cycle later.
- R5: In normal mode, `link_fail`=1 or `jabber`=1 keeps the turnaround off in that cycle.
- R6: With the strap `ext_lb_n`=0 and not forced, the turnaround stays off at all times and `col_out` is held 0.
- R7: With `tp_sel`=1 and `force_lb`=1, the turnaround is on regardless of collision, link failure, jabber or strap. `lb_active`=1 even with transmit idle, `rxd_out`=`tx_data`, `rxdv_out`=`tx_en`, and `col_out` repeats `col_in`.
- R8: With `tp_sel`=0, `force_lb` has no effect and the strap and normal rules apply.
- R9: A change of `tp_sel`, `force_lb` or `ext_lb_n` is taken only on a cycle with `tx_en`=0 or on the cycle `tx_en` rises. During a frame the mode in force at its start is kept.
- R10: Every output reflects the inputs sampled at the previous rising clock edge, exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | DATA_W | Transmit data from the back-end |
| tx_en | input | 1 | Transmit enable from the back-end |
| rx_data | input | DATA_W | Decoded line receive data |
| rx_crs | input | 1 | Line carrier present |
| col_in | input | 1 | Raw collision indication |
| link_fail | input | 1 | Link-fail state flag |
| jabber | input | 1 | Jabber state flag |
| ext_lb_n | input | 1 | Strap; 0 disables turnaround and collision reporting |
| tp_sel | input | 1 | Twisted-pair port selected |
| force_lb | input | 1 | Forced-loopback control bit |
| rxd_out | output | DATA_W | Selected receive data to the back-end |
| rxdv_out | output | 1 | Valid flag for `rxd_out` |
| col_out | output | 1 | Gated collision indication |
| lb_active | output | 1 | Internal turnaround active |

## Verification
The hardest case to reach is a mode request that changes in the middle of a frame. It must be ignored until transmit goes idle, and it interacts with the frame-long collision block. The stimulus starts normal frames, raises the forced and strap controls while `tx_en` is held, and drops them again before the frame ends. It also injects single-cycle collisions partway through frames, so the bench can tell the frame-long block from simple collision tracking. A long stretch of randomly weighted inputs then runs against the behavioural reference model.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_STRAP  = 2'd1,
        MODE_FORCED = 2'd2
    } lb_mode_e;

    typedef struct packed {
        logic loop;
        logic col;
    } path_sel_t;

    function automatic lb_mode_e mode_request(input logic tp_sel,
                                              input logic force_lb,
                                              input logic ext_lb_n);
        if (tp_sel && force_lb)
            return MODE_FORCED;
        else if (!ext_lb_n)
            return MODE_STRAP;
        else
            return MODE_NORMAL;
    endfunction

endpackage

// File: rtl/lbk_mode_sel.sv
module lbk_mode_sel
    import lbk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tx_en,
    input  logic     tp_sel,
    input  logic     force_lb,
    input  logic     ext_lb_n,
    output lb_mode_e mode_eff
);
    lb_mode_e mode_q;
    lb_mode_e mode_req;
    logic     tx_en_q;
    logic     take_new;

    always_comb begin
        mode_req = mode_request(tp_sel, force_lb, ext_lb_n);
        take_new = !tx_en || !tx_en_q;
        mode_eff = take_new ? mode_req : mode_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_NORMAL;
            tx_en_q <= 1'b0;
        end else begin
            mode_q  <= mode_eff;
            tx_en_q <= tx_en;
        end
    end

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (tx_en && $past(tx_en) && !$past(rst)) |-> (mode_eff == $past(mode_eff))) // R9
        else $error("mode changed inside a frame");

endmodule

// File: rtl/lbk_loop_arb.sv
module lbk_loop_arb
    import lbk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lb_mode_e  mode,
    input  logic      tx_en,
    input  logic      col_in,
    input  logic      link_fail,
    input  logic      jabber,
    output path_sel_t sel
);
    logic col_block_q;
    logic normal_ok;

    always_comb begin
        normal_ok = tx_en && !col_in && !col_block_q && !link_fail && !jabber;
        unique case (mode)
            MODE_FORCED: begin
                sel.loop = 1'b1;
                sel.col  = col_in;
            end
            MODE_STRAP: begin
                sel.loop = 1'b0;
                sel.col  = 1'b0;
            end
            default: begin
                sel.loop = normal_ok;
                sel.col  = col_in;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            col_block_q <= 1'b0;
        else
            col_block_q <= tx_en && (col_block_q || col_in);
    end

    AST_STRAP_NO_LOOP: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_STRAP) |-> (!sel.loop && !sel.col)) // R6
        else $error("strap mode allowed loop or collision");

endmodule

// File: rtl/lbk_out_reg.sv
module lbk_out_reg
    import lbk_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  path_sel_t         sel,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_en,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_crs,
    output logic [DATA_W-1:0] rxd_out,
    output logic              rxdv_out,
    output logic              col_out,
    output logic              lb_active
);
    logic [DATA_W-1:0] rxd_nxt;
    logic              dv_nxt;

    always_comb begin
        rxd_nxt = sel.loop ? tx_data : rx_data;
        dv_nxt  = sel.loop ? tx_en   : rx_crs;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rxd_out   <= '0;
            rxdv_out  <= 1'b0;
            col_out   <= 1'b0;
            lb_active <= 1'b0;
        end else begin
            rxd_out   <= rxd_nxt;
            rxdv_out  <= dv_nxt;
            col_out   <= sel.col;
            lb_active <= sel.loop;
        end
    end

    AST_LOOP_DATA: assert property (@(posedge clk) disable iff (rst)
        lb_active |-> (rxd_out == $past(tx_data) && rxdv_out == $past(tx_en))) // R2
        else $error("loop data mismatch");

endmodule

// File: rtl/lbk_path_ctrl.sv
module lbk_path_ctrl
    import lbk_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_en,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_crs,
    input  logic              col_in,
    input  logic              link_fail,
    input  logic              jabber,
    input  logic              ext_lb_n,
    input  logic              tp_sel,
    input  logic              force_lb,
    output logic [DATA_W-1:0] rxd_out,
    output logic              rxdv_out,
    output logic              col_out,
    output logic              lb_active
);
    lb_mode_e  mode_eff;
    path_sel_t sel;

    lbk_mode_sel u_mode (
        .clk      (clk),
        .rst      (rst),
        .tx_en    (tx_en),
        .tp_sel   (tp_sel),
        .force_lb (force_lb),
        .ext_lb_n (ext_lb_n),
        .mode_eff (mode_eff)
    );

    lbk_loop_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_eff),
        .tx_en     (tx_en),
        .col_in    (col_in),
        .link_fail (link_fail),
        .jabber    (jabber),
        .sel       (sel)
    );

    lbk_out_reg #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .tx_data   (tx_data),
        .tx_en     (tx_en),
        .rx_data   (rx_data),
        .rx_crs    (rx_crs),
        .rxd_out   (rxd_out),
        .rxdv_out  (rxdv_out),
        .col_out   (col_out),
        .lb_active (lb_active)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!lb_active && !rxdv_out && !col_out && rxd_out == '0)) // R1
        else $error("reset state wrong");

    AST_FORCE_LOOP: assert property (@(posedge clk) disable iff (rst)
        (tp_sel && force_lb && !tx_en) |=> lb_active) // R7
        else $error("forced loop not active");

    AST_FAULT_NO_LOOP: assert property (@(posedge clk) disable iff (rst)
        ((mode_eff == MODE_NORMAL) && (link_fail || jabber)) |=> !lb_active) // R5
        else $error("loop despite link fail or jabber");

    AST_STRAP_COL_LOW: assert property (@(posedge clk) disable iff (rst)
        (!ext_lb_n && !(tp_sel && force_lb) && !tx_en) |=> !col_out) // R6
        else $error("collision passed in strap mode");

endmodule

// File: tb/lbk_path_ctrl_tb.sv
module lbk_path_ctrl_tb;
    localparam int DW = 4;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst;
    logic [DW-1:0] tx_data, rx_data;
    logic          tx_en, rx_crs, col_in, link_fail, jabber, ext_lb_n, tp_sel, force_lb;
    logic [DW-1:0] rxd_out;
    logic          rxdv_out, col_out, lb_active;

    int    n_checks = 0;
    int    n_errors = 0;
    string req_tag  = "R1";
    bit    armed    = 1'b0;
    bit    done     = 1'b0;

    // reference model state
    int            m_mode;      // 0 normal, 1 strap, 2 forced
    bit            m_prev_tx;
    bit            m_blk;
    logic [DW-1:0] e_rxd;
    bit            e_dv, e_col, e_lb;

    always #(CLK_PERIOD/2) clk = ~clk;

    lbk_path_ctrl #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .tx_data(tx_data), .tx_en(tx_en),
        .rx_data(rx_data), .rx_crs(rx_crs), .col_in(col_in),
        .link_fail(link_fail), .jabber(jabber), .ext_lb_n(ext_lb_n),
        .tp_sel(tp_sel), .force_lb(force_lb), .rxd_out(rxd_out),
        .rxdv_out(rxdv_out), .col_out(col_out), .lb_active(lb_active)
    );

    always @(posedge clk) begin
        bit loop;
        int req;
        armed <= 1'b1;
        if (rst) begin
            m_mode = 0; m_prev_tx = 0; m_blk = 0;
            e_rxd = '0; e_dv = 0; e_col = 0; e_lb = 0;
        end else begin
            if (tp_sel && force_lb) req = 2;
            else if (!ext_lb_n)    req = 1;
            else                   req = 0;
            if (!tx_en || !m_prev_tx) m_mode = req;
            case (m_mode)
                2:       loop = 1;
                1:       loop = 0;
                default: loop = tx_en && !col_in && !m_blk && !link_fail && !jabber;
            endcase
            e_lb  = loop;
            e_rxd = loop ? tx_data : rx_data;
            e_dv  = loop ? tx_en : rx_crs;
            e_col = (m_mode == 1) ? 1'b0 : col_in;
            m_blk = tx_en && (m_blk || col_in);
            m_prev_tx = tx_en;
        end
    end

    always @(negedge clk) begin
        if (armed && !done) begin
            n_checks++;
            if (rxd_out !== e_rxd || rxdv_out !== e_dv || col_out !== e_col || lb_active !== e_lb) begin
                n_errors++;
                $display("FAIL %s: actual rxd=%h dv=%b col=%b lb=%b expected rxd=%h dv=%b col=%b lb=%b",
                         req_tag, rxd_out, rxdv_out, col_out, lb_active, e_rxd, e_dv, e_col, e_lb);
            end
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            tx_data = DW'($urandom);
            rx_data = DW'($urandom);
        end
    endtask

    task automatic idle_defaults();
        tx_en = 0; rx_crs = 0; col_in = 0; link_fail = 0; jabber = 0;
        ext_lb_n = 1; tp_sel = 1; force_lb = 0;
    endtask

    initial begin
        rst = 1; tx_data = '0; rx_data = '0;
        idle_defaults();
        req_tag = "R1";
        step(3);
        rst = 0;
        step(2);

        req_tag = "R2";                       // normal turnaround
        tx_en = 1; step(6); tx_en = 0; step(2);

        req_tag = "R3";                       // line data while idle
        rx_crs = 1; step(5); rx_crs = 0; step(2);

        req_tag = "R4";                       // one-cycle collision blocks rest of frame
        tx_en = 1; rx_crs = 1; step(3); col_in = 1; step(1); col_in = 0; step(4);
        tx_en = 0; rx_crs = 0; step(2);

        req_tag = "R5";
        tx_en = 1; step(2); link_fail = 1; step(2); link_fail = 0; step(2);
        jabber = 1; step(2); jabber = 0; step(1); tx_en = 0; step(2);

        req_tag = "R6";                       // strap low
        ext_lb_n = 0; step(1);
        tx_en = 1; rx_crs = 1; step(2); col_in = 1; step(2); col_in = 0; step(2);
        tx_en = 0; rx_crs = 0; col_in = 1; step(2); col_in = 0; step(1);
        ext_lb_n = 1; step(1);

        req_tag = "R7";                       // forced over everything
        force_lb = 1; step(2);
        tx_en = 1; col_in = 1; link_fail = 1; jabber = 1; ext_lb_n = 0; rx_crs = 1; step(4);
        col_in = 0; link_fail = 0; jabber = 0; step(2);
        tx_en = 0; rx_crs = 0; step(2); ext_lb_n = 1; force_lb = 0; step(2);

        req_tag = "R8";                       // force without port select
        tp_sel = 0; force_lb = 1; step(1);
        tx_en = 1; step(2); col_in = 1; step(1); col_in = 0; step(2); tx_en = 0; step(1);
        ext_lb_n = 0; step(1); tx_en = 1; step(2); tx_en = 0; step(1);
        ext_lb_n = 1; tp_sel = 1; force_lb = 0; step(2);

        req_tag = "R9";                       // mode change mid-frame ignored
        tx_en = 1; step(2); force_lb = 1; step(3); ext_lb_n = 0; step(2);
        tx_en = 0; step(1); tx_en = 1; step(3);    // now forced
        force_lb = 0; step(3);                     // strap request held off
        tx_en = 0; step(2); tx_en = 1; step(2);    // strap taken at rise
        ext_lb_n = 1; step(2); tx_en = 0; step(2);

        req_tag = "R10";                      // weighted random traffic
        for (int i = 0; i < 3000; i++) begin
            tx_en     = ($urandom % 8) != 0 ? tx_en : ~tx_en;
            rx_crs    = ($urandom % 3) == 0;
            col_in    = ($urandom % 10) == 0;
            link_fail = ($urandom % 16) == 0;
            jabber    = ($urandom % 20) == 0;
            ext_lb_n  = ($urandom % 12) != 0;
            tp_sel    = ($urandom % 6) != 0;
            force_lb  = ($urandom % 5) == 0;
            if (($urandom % 97) == 0) rst = 1;
            step(1);
            rst = 0;
        end
        step(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule